// File: doc/BRIEF.md
# Conditional-block state and condition evaluator

This unit keeps the eight-bit state of a compact-encoding conditional block (a short run of up to four instructions that each execute under a shared base condition or its inverse) and decides whether the instruction now retiring may take effect. The decode stage loads a fresh state when it sees the block-opening instruction. After that, the retire stage pulses an advance strobe once for each instruction that completes, and the state steps through the block until its mask runs out.

Outside a block the unit works as a plain condition checker. It evaluates the four-bit condition field supplied by the decoder against the N, Z, C and V flags. All of its pins are control or status signals with no stream of data, so the interface carries no valid/ready handshake.

Top module: `itc_tracker`

## Requirements
- R1: A synchronous reset drives the state to 8'h00, so the block flag is low and the effective condition equals the external condition input.
- R2: When the load strobe is high, the state takes the load value on the next clock edge, even if the advance strobe is high in the same cycle.
- R3: On an advance without a load, the next state keeps state[7:5], takes old state[3:0] shifted left by one into bits [4:0], and puts a zero in bit 0.
- R4: If the shifted value from R3 has bits [3:0] all zero, the next state is 8'h00.
- R5: The block flag is high exactly when state[3:0] is nonzero. The effective condition is then state[7:4]; otherwise it is the external condition input.
- R6: Condition codes 4'hE and 4'hF always pass.
- R7: Codes 0/1 pass on Z set/clear, 2/3 on C set/clear, 4/5 on N set/clear, and 6/7 on V set/clear.
- R8: Code 8 passes when C=1 and Z=0. Code 9 passes in every other case.
- R9: Code A passes when N==V and code B when N!=V. Code C passes when Z=0 and N==V. Code D passes when Z=1 or N!=V.
- R10: The pass output is combinational from the flags and the effective condition, and is valid in the same cycle.
- R11: With neither strobe high, the state holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| load_en | input | 1 | Load strobe |
| load_state | input | 8 | State to load |
| adv_en | input | 1 | Advance strobe, one pulse per retired instruction |
| ext_cond | input | 4 | Condition code used outside a block |
| cur_state | output | 8 | Current state |
| in_block | output | 1 | High while inside a conditional block |
| eff_cond | output | 4 | Condition being evaluated |
| cond_pass | output | 1 | High when the effective condition passes |

## Verification
The state-related results (cur_state, in_block, and the effective condition taken from the state) change one clock edge after a load, an advance or a reset. The bench drives strobes just after a falling edge and reads these outputs just after the following falling edge, which is half a period after the registering edge. The pass result and the effective condition taken from ext_cond are combinational, so the condition table is checked after a short settle delay in the same cycle, with no edge in between.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int unsigned STATE_W = 8;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned MASK_W  = 4;

  typedef enum logic [COND_W-1:0] {
    C_EQ = 4'h0, C_NE = 4'h1, C_CS = 4'h2, C_CC = 4'h3,
    C_MI = 4'h4, C_PL = 4'h5, C_VS = 4'h6, C_VC = 4'h7,
    C_HI = 4'h8, C_LS = 4'h9, C_GE = 4'hA, C_LT = 4'hB,
    C_GT = 4'hC, C_LE = 4'hD, C_AL = 4'hE, C_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/itc_state_reg.sv
module itc_state_reg
  import itc_pkg::*;
#(
  parameter int unsigned SW = STATE_W,
  parameter int unsigned MW = MASK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [SW-1:0] load_state,
  input  logic          adv_en,
  output logic [SW-1:0] state_q
);
  localparam int unsigned KEEP_LSB = MW + 1;

  logic [SW-1:0] shifted;
  logic [SW-1:0] state_d;

  always_comb begin
    shifted = {state_q[SW-1:KEEP_LSB], state_q[MW-1:0], 1'b0};
    if (shifted[MW-1:0] == '0) shifted = '0;
  end

  always_comb begin
    state_d = state_q;
    if (load_en)     state_d = load_state;
    else if (adv_en) state_d = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> state_q == '0); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state_q == $past(load_state)); // R2
  AST_ADV_KEEP_TOP: assert property (@(posedge clk) disable iff (rst)
    (!load_en && adv_en && state_q[MW-2:0] != '0)
      |=> state_q[SW-1:KEEP_LSB] == $past(state_q[SW-1:KEEP_LSB])); // R3
  AST_ADV_END_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!load_en && adv_en && state_q[MW-2:0] == '0) |=> state_q == '0); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !adv_en) |=> $stable(state_q)); // R11
endmodule

// File: rtl/itc_cond_eval.sv
module itc_cond_eval
  import itc_pkg::*;
(
  input  flags_t            flags,
  input  logic [COND_W-1:0] cond,
  output logic              pass
);
  logic base;
  logic nv_eq;

  assign nv_eq = (flags.n == flags.v);

  always_comb begin
    unique case (cond[COND_W-1:1])
      3'd0: base = flags.z;
      3'd1: base = flags.c;
      3'd2: base = flags.n;
      3'd3: base = flags.v;
      3'd4: base = flags.c & ~flags.z;
      3'd5: base = nv_eq;
      3'd6: base = ~flags.z & nv_eq;
      default: base = 1'b1;
    endcase
    if (cond[COND_W-1:1] == 3'd7) pass = 1'b1;
    else                          pass = base ^ cond[0];
  end

  always_comb begin
    if (cond == C_AL || cond == C_NV) AST_ALWAYS_PASS: assert (pass); // R6
  end
endmodule

// File: rtl/itc_tracker.sv
module itc_tracker
  import itc_pkg::*;
#(
  parameter int unsigned SW = STATE_W,
  parameter int unsigned CW = COND_W,
  parameter int unsigned MW = MASK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_v,
  input  logic          load_en,
  input  logic [SW-1:0] load_state,
  input  logic          adv_en,
  input  logic [CW-1:0] ext_cond,
  output logic [SW-1:0] cur_state,
  output logic          in_block,
  output logic [CW-1:0] eff_cond,
  output logic          cond_pass
);
  flags_t flags;
  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  itc_state_reg #(.SW(SW), .MW(MW)) i_state (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(load_state),
    .adv_en(adv_en), .state_q(cur_state)
  );

  assign in_block = |cur_state[MW-1:0];
  assign eff_cond = in_block ? cur_state[SW-1:SW-CW] : ext_cond;

  itc_cond_eval i_eval (.flags(flags), .cond(eff_cond), .pass(cond_pass));

  AST_OUT_BLOCK_EXT: assert property (@(posedge clk) disable iff (rst)
    (cur_state == '0) |-> eff_cond == ext_cond); // R5
  AST_PASS_GE_LT: assert property (@(posedge clk) disable iff (rst)
    (eff_cond == 4'hA) |-> cond_pass == (flag_n == flag_v)); // R9
endmodule

// File: tb/test_itc_tracker.sv
module test_itc_tracker;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fn = 0, fz = 0, fc = 0, fv = 0;
  logic load_en = 0, adv_en = 0;
  logic [7:0] load_state = 0;
  logic [3:0] ext_cond = 0;
  logic [7:0] cur_state;
  logic in_block, cond_pass;
  logic [3:0] eff_cond;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itc_tracker i_itc_tracker (
    .clk(clk), .rst(rst), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .load_en(load_en), .load_state(load_state), .adv_en(adv_en),
    .ext_cond(ext_cond), .cur_state(cur_state), .in_block(in_block),
    .eff_cond(eff_cond), .cond_pass(cond_pass)
  );

  // vector: {cond, n, z, c, v, expected pass}
  localparam int NV = 24;
  localparam logic [8:0] VEC [NV] = '{
    {4'h0,4'b0100,1'b1},{4'h0,4'b0000,1'b0},{4'h1,4'b0100,1'b0},
    {4'h2,4'b0010,1'b1},{4'h3,4'b0010,1'b0},{4'h4,4'b1000,1'b1},
    {4'h5,4'b1000,1'b0},{4'h6,4'b0001,1'b1},{4'h7,4'b0001,1'b0},
    {4'h8,4'b0010,1'b1},{4'h8,4'b0110,1'b0},{4'h9,4'b0110,1'b1},
    {4'h9,4'b0010,1'b0},{4'hA,4'b1001,1'b1},{4'hA,4'b1000,1'b0},
    {4'hB,4'b0001,1'b1},{4'hC,4'b0000,1'b1},{4'hC,4'b0100,1'b0},
    {4'hD,4'b0100,1'b1},{4'hD,4'b1001,1'b0},{4'hE,4'b0000,1'b1},
    {4'hF,4'b1111,1'b1},{4'hB,4'b1001,1'b0},{4'h1,4'b0000,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0; #1;
    chk("R1 state", cur_state, 8'h00);
    chk("R1 in_block", in_block, 0);
    ext_cond = 4'h7; #1;
    chk("R5 eff ext", eff_cond, 4'h7);

    // table walk, outside block: R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      ext_cond = VEC[i][8:5];
      {fn, fz, fc, fv} = VEC[i][4:1];
      #1;
      chk("R10 cond table", {ext_cond, cond_pass}, {VEC[i][8:5], VEC[i][0]});
    end

    // R2: load 0x0C -> cond 0, mask 1100
    load_state = 8'h0C; load_en = 1; step(); load_en = 0;
    chk("R2 load", cur_state, 8'h0C);
    chk("R5 in_block", in_block, 1);
    ext_cond = 4'hE; {fn, fz, fc, fv} = 4'b0000; #1;
    chk("R5 eff state", eff_cond, 4'h0);
    chk("R10 in-block pass EQ z=0", cond_pass, 0);
    step();
    chk("R11 hold", cur_state, 8'h0C);
    // R3: advance 0x0C -> 0x18
    adv_en = 1; step();
    chk("R3 advance", cur_state, 8'h18);
    chk("R3 eff cond", eff_cond, 4'h1);
    step(); // 0x18 -> shifted 0x10, low nibble 0 -> R4 clear
    adv_en = 0;
    chk("R4 clear", cur_state, 8'h00);
    chk("R4 out of block", in_block, 0);

    // R3 with top bits: 0xE7 -> {111, 0111, 0}=0xEE
    load_state = 8'hE7; load_en = 1; step(); load_en = 0;
    adv_en = 1; step(); adv_en = 0;
    chk("R3 keep top", cur_state, 8'hEE);

    // R2 priority: load and advance together
    load_state = 8'h5A; load_en = 1; adv_en = 1; step();
    load_en = 0; adv_en = 0;
    chk("R2 priority", cur_state, 8'h5A);

    // R4 when mask is 1000: 0xA8 -> 0
    load_state = 8'hA8; load_en = 1; step(); load_en = 0;
    adv_en = 1; step(); adv_en = 0;
    chk("R4 last", cur_state, 8'h00);

    // R1 mid-block reset
    load_state = 8'h34; load_en = 1; step(); load_en = 0;
    rst = 1; step(); rst = 0;
    chk("R1 reset clears", cur_state, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule